// File: doc/BRIEF.md
# Fast Fault Shutdown Controller

This block holds the digital decision logic that sits between an overcurrent comparator, the shared active-low shutdown/fault pin and the gate drivers of a multi-leg inverter. When the comparator trips, the gate-kill outputs rise in the same clock cycle through a path that does not pass through any register. The driver is therefore switched off without waiting for the RC-filtered shutdown pin to discharge.

On the clock edge that follows a trip, the block turns on an open-drain pull-down on the shutdown pin. It holds that pull-down until the digitized pin level reports that the pin has fallen below its lower input threshold. The pull-down is then released and the external resistor recharges the pin. Driving is allowed again only once the pin is seen above its upper threshold. The external RC time constant therefore sets the extended disable time, and no counter inside the block is involved. A low level forced onto the pin from outside also disables the drivers. The pin level is delivered as two already synchronized threshold bits, and the block adds hysteresis between them.

Top module: `fault_shutdown_ctrl`

## Requirements
- R1: While reset is held, every gate-kill bit is 1 and the pull-down enable is 0.
- R2: In any state, a 1 on the trip input drives every gate-kill bit to 1 in the same cycle, whatever the pin level bits show.
- R3: A trip sampled at a clock edge while the pull-down is off turns the pull-down on from that edge onward.
- R4: Once on, the pull-down stays on at every edge where the below-lower bit is 0, even after the trip input returns to 0.
- R5: An edge that samples the below-lower bit at 1 while the pull-down is on turns the pull-down off. The gate-kill bits stay at 1 afterwards.
- R6: After reset or after a release, gate-kill stays 1 until an edge samples the above-upper bit at 1 with no trip present. From the cycle after that edge, gate-kill is 0.
- R7: A trip that arrives while the block is recovering (pull-down off, gate-kill held) turns the pull-down on again from the next edge.
- R8: The pin counts as high only after the above-upper bit has been seen. With both level bits at 0, the last level is kept. While driving, an edge that samples the below-lower bit at 1 sets gate-kill to 1 from the next cycle without turning on the pull-down. Driving resumes in the cycle after an edge that samples above-upper at 1.
- R9: All gate-kill bits carry the same value in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trip_i | input | 1 | Overcurrent comparator trip, already synchronized |
| sd_above_upper_i | input | 1 | Shutdown pin is above its upper input threshold |
| sd_below_lower_i | input | 1 | Shutdown pin is below its lower input threshold |
| gate_kill_o | output | NUM_LEGS | Per-leg force-off of both gate outputs |
| od_pulldown_o | output | 1 | Enable of the open-drain pull-down on the shutdown pin |

## Verification
The assertions rely on one property of the inputs: the two threshold bits come from one analog pin with separated thresholds, so they are never 1 together. A checker flags any stimulus that breaks this. The bench drives only the legal level codes 00, 10 and 01, and it holds the 00 code for several cycles to exercise the hysteresis. Trip pulses are applied with the pin above the upper threshold, between the thresholds and during recovery. This covers both the direct kill path and the re-entry into pull-down.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_PULLDOWN = 2'd1,
    ST_RECOVER  = 2'd2
  } fsd_state_e;

  // Pin level with hysteresis: set above upper, clear below lower, else hold.
  function automatic logic level_next(logic cur, logic above, logic below);
    if (below)      return 1'b0;
    else if (above) return 1'b1;
    else            return cur;
  endfunction

  function automatic fsd_state_e state_next(fsd_state_e cur, logic trip,
                                            logic above, logic below);
    case (cur)
      ST_RUN:      return trip ? ST_PULLDOWN : ST_RUN;
      ST_PULLDOWN: return below ? ST_RECOVER : ST_PULLDOWN;
      ST_RECOVER: begin
        if (trip)       return ST_PULLDOWN;
        else if (above) return ST_RUN;
        else            return ST_RECOVER;
      end
      default:     return ST_RECOVER;
    endcase
  endfunction

endpackage

// File: rtl/fsd_level_track.sv
module fsd_level_track (
  input  logic clk,
  input  logic rst_n,
  input  logic above_i,
  input  logic below_i,
  output logic pin_high_o
);
  import fsd_pkg::*;

  logic pin_high_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_high_q <= 1'b0;
    else        pin_high_q <= level_next(pin_high_q, above_i, below_i);
  end

  assign pin_high_o = pin_high_q;
endmodule

// File: rtl/fsd_state_ctrl.sv
module fsd_state_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic above_i,
  input  logic below_i,
  output logic running_o,
  output logic pulldown_o,
  output logic trip_evt_o,
  output logic release_evt_o,
  output logic resume_evt_o
);
  import fsd_pkg::*;

  fsd_state_e state_q, state_d;

  assign state_d = state_next(state_q, trip_i, above_i, below_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RECOVER;
    else        state_q <= state_d;
  end

  assign running_o     = (state_q == ST_RUN);
  assign pulldown_o    = (state_q == ST_PULLDOWN);
  assign trip_evt_o    = (state_q != ST_PULLDOWN) && (state_d == ST_PULLDOWN);
  assign release_evt_o = (state_q == ST_PULLDOWN) && (state_d == ST_RECOVER);
  assign resume_evt_o  = (state_q == ST_RECOVER)  && (state_d == ST_RUN);
endmodule

// File: rtl/fsd_kill_fanout.sv
module fsd_kill_fanout #(
  parameter int NUM_LEGS = 3
) (
  input  logic                trip_i,
  input  logic                running_i,
  input  logic                pin_high_i,
  output logic [NUM_LEGS-1:0] kill_o
);
  logic kill_any;

  // Unregistered trip path ORed with the registered hold conditions.
  assign kill_any = trip_i | ~running_i | ~pin_high_i;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    assign kill_o[g] = kill_any;
  end
endmodule

// File: rtl/fault_shutdown_ctrl.sv
module fault_shutdown_ctrl #(
  parameter int NUM_LEGS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trip_i,
  input  logic                sd_above_upper_i,
  input  logic                sd_below_lower_i,
  output logic [NUM_LEGS-1:0] gate_kill_o,
  output logic                od_pulldown_o
);
  logic pin_high;
  logic running;
  logic trip_evt;
  logic release_evt;
  logic resume_evt;

  fsd_level_track u_level (
    .clk        (clk),
    .rst_n      (rst_n),
    .above_i    (sd_above_upper_i),
    .below_i    (sd_below_lower_i),
    .pin_high_o (pin_high)
  );

  fsd_state_ctrl u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .trip_i        (trip_i),
    .above_i       (sd_above_upper_i),
    .below_i       (sd_below_lower_i),
    .running_o     (running),
    .pulldown_o    (od_pulldown_o),
    .trip_evt_o    (trip_evt),
    .release_evt_o (release_evt),
    .resume_evt_o  (resume_evt)
  );

  fsd_kill_fanout #(.NUM_LEGS(NUM_LEGS)) u_kill (
    .trip_i     (trip_i),
    .running_i  (running),
    .pin_high_i (pin_high),
    .kill_o     (gate_kill_o)
  );
endmodule

// File: rtl/fsd_checker.sv
module fsd_checker #(
  parameter int NUM_LEGS = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                trip_i,
  input logic                sd_above_upper_i,
  input logic                sd_below_lower_i,
  input logic [NUM_LEGS-1:0] gate_kill_o,
  input logic                od_pulldown_o,
  input logic                trip_evt,
  input logic                release_evt,
  input logic                resume_evt
);
  // input constraint used by all checks below
  level_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sd_above_upper_i && sd_below_lower_i));

  // R2
  trip_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_i |-> (&gate_kill_o));

  // R3
  pulldown_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_i && !od_pulldown_o) |=> od_pulldown_o);

  // R4
  pulldown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (od_pulldown_o && !sd_below_lower_i) |=> od_pulldown_o);

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> (!od_pulldown_o && (&gate_kill_o)));

  // R5
  kill_in_pulldown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    od_pulldown_o |-> (&gate_kill_o));

  // R6
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_evt && !trip_i) |-> (sd_above_upper_i && !od_pulldown_o));

  // R7
  trip_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt |-> trip_i);

  // R8
  ext_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_below_lower_i |=> (&gate_kill_o));

  // R9
  legs_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&gate_kill_o) || (gate_kill_o == '0)));
endmodule

bind fault_shutdown_ctrl fsd_checker #(.NUM_LEGS(NUM_LEGS)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .trip_i           (trip_i),
  .sd_above_upper_i (sd_above_upper_i),
  .sd_below_lower_i (sd_below_lower_i),
  .gate_kill_o      (gate_kill_o),
  .od_pulldown_o    (od_pulldown_o),
  .trip_evt         (trip_evt),
  .release_evt      (release_evt),
  .resume_evt       (resume_evt)
);

// File: tb/fault_shutdown_ctrl_tb.sv
module fault_shutdown_ctrl_tb;
  localparam int NUM_LEGS = 3;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                trip = 1'b0;
  logic                above = 1'b0;
  logic                below = 1'b0;
  logic [NUM_LEGS-1:0] kill;
  logic                pd;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    logic  kill;
    logic  pd;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  fault_shutdown_ctrl #(.NUM_LEGS(NUM_LEGS)) u_dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .trip_i           (trip),
    .sd_above_upper_i (above),
    .sd_below_lower_i (below),
    .gate_kill_o      (kill),
    .od_pulldown_o    (pd)
  );

  // driver: inputs for one cycle plus the outputs expected before its closing edge
  task automatic step(input logic t, input logic up, input logic lo,
                      input logic ek, input logic ep, input string tag);
    @(negedge clk);
    trip  = t;
    above = up;
    below = lo;
    sb_q.push_back('{kill: ek, pd: ep, tag: tag});
  endtask

  // monitor: compares in the second half of each cycle, away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        logic [NUM_LEGS-1:0] ek_vec;
        e = sb_q.pop_front();
        ek_vec = {NUM_LEGS{e.kill}};
        tests++;
        if (kill !== ek_vec || pd !== e.pd) begin
          fails++;
          $display("FAIL %s: kill=%b pd=%b expected kill=%b pd=%b",
                   e.tag, kill, pd, ek_vec, e.pd);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    tests++;
    if (kill !== {NUM_LEGS{1'b1}} || pd !== 1'b0) begin
      fails++;
      $display("FAIL R1: kill=%b pd=%b expected kill=%b pd=0", kill, pd,
               {NUM_LEGS{1'b1}});
    end
    @(negedge clk);
    rst_n = 1'b1;

    // recovery after reset, then resume via upper threshold
    step(0, 0, 0, 1, 0, "R6 held after reset");
    step(0, 0, 0, 1, 0, "R6 held after reset");
    step(0, 1, 0, 1, 0, "R6 above seen this cycle");
    step(0, 0, 0, 0, 0, "R6 resume / R8 hysteresis");
    step(0, 0, 0, 0, 0, "R8 level held between thresholds");
    // trip with the pin between thresholds
    step(1, 0, 0, 1, 0, "R2 same-cycle kill");
    step(0, 0, 0, 1, 1, "R3 pulldown on");
    step(0, 1, 0, 1, 1, "R4 pulldown held, pin high");
    step(0, 0, 0, 1, 1, "R4 pulldown held");
    step(1, 0, 0, 1, 1, "R4 pulldown held during trip");
    step(0, 0, 1, 1, 1, "R5 below lower sampled");
    step(0, 0, 0, 1, 0, "R5 released, kill held");
    // retrip while recovering
    step(1, 0, 0, 1, 0, "R7 trip in recovery");
    step(0, 0, 0, 1, 1, "R7 pulldown again");
    step(0, 0, 1, 1, 1, "R5 second release");
    step(0, 0, 0, 1, 0, "R6 held after release");
    step(0, 0, 0, 1, 0, "R6 held after release");
    step(0, 1, 0, 1, 0, "R6 above seen");
    step(0, 0, 0, 0, 0, "R6 driving resumed");
    // external low while driving
    step(0, 0, 1, 0, 0, "R8 below sampled this cycle");
    step(0, 0, 0, 1, 0, "R8 external low kills, no pulldown");
    step(0, 0, 0, 1, 0, "R8 low level held");
    step(0, 1, 0, 1, 0, "R8 above seen");
    step(0, 0, 0, 0, 0, "R8 driving resumed");
    // trip with pin above upper, trip lasting two cycles
    step(1, 1, 0, 1, 0, "R2 kill with pin high");
    step(1, 1, 0, 1, 1, "R3 pulldown on, R9 legs equal");
    step(0, 1, 0, 1, 1, "R4 held after trip clears");
    step(0, 0, 1, 1, 1, "R5 below sampled");
    step(0, 1, 0, 1, 0, "R6 above in recovery");
    step(0, 1, 0, 0, 0, "R6 resume, R9 legs equal");
    step(0, 0, 0, 0, 0, "R9 idle driving");

    @(negedge clk);
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule